// File: doc/BRIEF.md
# Command-Driven Serial Flash Word Engine

This block is a serial-peripheral master that moves one word per command to or from a flash device on one of four chip selects. A host writes a clock word, a device-control word holding one configuration byte per select, up to four transmit data words, and finally a command word. The engine then drives the serial clock, the chip select and the data line. It captures receive data from one or four input lines and reports completion through two status outputs.

Consecutive commands form a frame, and the chip select stays asserted between the words of that frame. The frame ends when its programmed word count has been used up, or earlier when an invalidate command arrives. Words can be 1 to 128 bits long, taken from four stacked data registers. A delay of up to three serial-clock periods can be inserted between chip-select assertion and the first clock edge.

The control path is a three-state machine:
- ST_IDLE is the state after reset and after every word.
- ST_IDLE goes to ST_DELAY when an accepted data command opens a new frame on a select whose delay field is non-zero.
- ST_IDLE goes to ST_SHIFT when an accepted data command continues an open frame, or opens one with a zero delay.
- ST_DELAY goes to ST_SHIFT after two divider ticks per programmed delay period.
- ST_SHIFT goes back to ST_IDLE on the tick that makes the last clock edge of the word.

Top module: `sfx_engine`

## Requirements
- R1: After reset the outputs are as follows.
  - `busy`, `word_done`, `sclk` and `mosi` are 0, and `rx_word` is zero.
  - Every `cs_o` line is high, because each select is inactive with its default active-low polarity.
- R2: The host registers are selected by `wr_addr`.
  - 0 is the clock word: bit 31 is the enable and bits [15:0] are the divider.
  - 1 is device control: byte n belongs to select n.
  - 2 is the command word.
  - 3 to 6 are the data registers. Register 3 holds the least significant 32 bits of a 128-bit word and register 6 the most significant.
- R3: The command word is laid out as follows.
  - Bits [11:0] are the frame length in words, [18:16] the operation, [25:19] the word length minus one, and [29:28] the select.
  - Operation 1 is a single-line read, 2 a single-line write, 4 an invalidate and 7 a quad read.
  - Any other operation has no effect.
- R4: A write sends the low L bits of the stacked data registers on `mosi`, most significant bit first. L is the word length.
- R5: A single-line read samples `dq_in[1]` once per clock period, most significant bit first. The L bits land in the low bits of `rx_word`, and the bits above them are zero.
- R6: A quad read samples `dq_in[3:0]` once per period, with line 3 the most significant, for ceil(L/4) periods.
- R7: Each half period of `sclk` lasts divider+1 cycles, so a word occupies the engine for 2·periods·(divider+1) cycles. Between words `sclk` rests at the clock polarity (device-control bit 0).
- R8: While the clock enable is 0, `sclk` holds its level and the word does not advance. The word resumes correctly once the enable returns to 1.
- R9: Device-control bit 2 selects the clock phase: with 0, data is sampled on leading edges; with 1, on trailing edges. Bit 1 set to 1 makes that select's chip select active high.
- R10: Chip select asserts when a frame's first command is accepted and stays asserted between the frame's words.
  - It releases after the word that uses up the frame count. A count of 0 acts as 1.
  - An invalidate command also releases it.
  - The select field of later commands in an open frame is ignored.
- R11: `word_done` rises as `busy` falls at the end of a word. It clears when the next valid command is accepted. A command written while busy is ignored.
- R12: When a frame opens, the first `sclk` edge is delayed by device-control bits [4:3] full clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register select |
| wr_data | input | 32 | Host write data |
| dq_in | input | 4 | Receive data lines from the flash |
| sclk | output | 1 | Serial clock |
| cs_o | output | 4 | Chip-select lines, one per select, polarity per device control |
| mosi | output | 1 | Serial transmit data |
| busy | output | 1 | A word is in progress |
| word_done | output | 1 | The last word has completed |
| rx_word | output | 128 | Received word, right-aligned |

## Verification
Writes are tried at three lengths:
- An 8-bit write checks basic shifting.
- A 16-bit write checks longer words.
- A 128-bit write tells whether the four data registers are stacked in the right order.

Reads are tried both ways:
- Single-line reads in both clock phases tell leading-edge sampling from trailing-edge sampling.
- A quad read tells line order and the period count from the single-line case.

Busy-cycle counts at divider values 0 to 3 tell the half-period length apart. A three-word frame whose later commands name another select, plus a frame cut short by an invalidate, tell holding the chip select from releasing it. A command written while busy, an undefined operation, a paused clock and a non-zero data delay each show up in the captured bits or in the timing of the first edge.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_SHIFT
    } sfx_state_e;

    localparam logic [2:0] OP_RD1   = 3'd1;
    localparam logic [2:0] OP_WR1   = 3'd2;
    localparam logic [2:0] OP_INVAL = 3'd4;
    localparam logic [2:0] OP_RD4   = 3'd7;

    typedef struct packed {
        logic [1:0] delay;
        logic       cpha;
        logic       cspol;
        logic       cpol;
    } devctl_t;

endpackage

// File: rtl/sfx_clkdiv.sv
module sfx_clkdiv #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt >= div) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = run && en && (cnt >= div);

    // R7: with a non-zero divider, ticks never come back to back
    a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/sfx_shift.sv
module sfx_shift #(
    parameter int MAXW = 128,
    parameter int LW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            load_rd,
    input  logic [LW-1:0]   wlen_m1,
    input  logic [MAXW-1:0] tx_word,
    input  logic            rd_q,
    input  logic            quad_q,
    input  logic            samp,
    input  logic            shft,
    input  logic [3:0]      dq_in,
    output logic            mosi,
    output logic [MAXW-1:0] rx_word
);

    localparam logic [LW-1:0] TOP = LW'(MAXW - 1);

    logic [MAXW-1:0] tx_sr;
    logic [MAXW-1:0] rx_sr;
    logic [LW-1:0]   shamt;

    assign shamt = TOP - wlen_m1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_rd ? '0 : (tx_word << shamt);
        end else if (shft) begin
            tx_sr <= tx_sr << 1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (load && load_rd) begin
            rx_sr <= '0;
        end else if (samp && rd_q) begin
            rx_sr <= quad_q ? {rx_sr[MAXW-5:0], dq_in} : {rx_sr[MAXW-2:0], dq_in[1]};
        end
    end

    assign mosi    = tx_sr[MAXW-1];
    assign rx_word = rx_sr;

    // R9: sampling and shifting never fall on the same clock edge
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(samp && shft));

    // R4: a new word is never loaded while bits are being sampled
    a_r4_load_apart: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !samp);

endmodule

// File: rtl/sfx_ctrl.sv
module sfx_ctrl
    import sfx_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int FRAME_W = 12,
    parameter int LW      = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_en,
    input  logic                      tick,
    input  logic                      cmd_wr,
    input  logic [FRAME_W-1:0]        cmd_len,
    input  logic [2:0]                cmd_op,
    input  logic [LW-1:0]             cmd_wlen_m1,
    input  logic [$clog2(NUM_CS)-1:0] cmd_cs,
    input  devctl_t                   dcs [NUM_CS],
    output logic                      busy,
    output logic                      done,
    output logic                      load,
    output logic                      load_rd,
    output logic                      rd_q,
    output logic                      quad_q,
    output logic                      samp,
    output logic                      shft,
    output logic                      sclk,
    output logic [NUM_CS-1:0]         cs_o
);

    localparam int CSW = $clog2(NUM_CS);
    localparam int HW  = LW + 2;

    sfx_state_e state, nxt;

    logic               accept, go, is_data, is_inval;
    logic               frame_on, phase_q;
    logic [FRAME_W-1:0] frame_left;
    logic [CSW-1:0]     cur_cs;
    logic [HW-1:0]      hcnt, hlast, hlast_new;
    logic [2:0]         dcnt, dly_last;
    logic [LW:0]        beats_new;
    logic               lead, trail, word_end;

    assign is_data  = (cmd_op == OP_RD1) || (cmd_op == OP_WR1) || (cmd_op == OP_RD4);
    assign is_inval = (cmd_op == OP_INVAL);
    assign accept   = cmd_wr && (state == ST_IDLE);
    assign go       = accept && is_data;

    assign beats_new = (cmd_op == OP_RD4) ? (({1'b0, cmd_wlen_m1} >> 2) + (LW+1)'(1))
                                          : ({1'b0, cmd_wlen_m1} + (LW+1)'(1));
    assign hlast_new = {beats_new, 1'b0} - HW'(1);

    assign lead     = (state == ST_SHIFT) && tick && !phase_q;
    assign trail    = (state == ST_SHIFT) && tick && phase_q;
    assign word_end = (state == ST_SHIFT) && tick && (hcnt == hlast);

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (go) nxt = (!frame_on && dcs[cmd_cs].delay != 2'd0) ? ST_DELAY : ST_SHIFT;
            ST_DELAY: if (tick && dcnt == dly_last) nxt = ST_SHIFT;
            ST_SHIFT: if (tick && hcnt == hlast) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // word and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_on   <= 1'b0;
            frame_left <= '0;
            cur_cs     <= '0;
            rd_q       <= 1'b0;
            quad_q     <= 1'b0;
            hcnt       <= '0;
            hlast      <= '0;
            dcnt       <= '0;
            dly_last   <= '0;
            phase_q    <= 1'b0;
            done       <= 1'b0;
        end else begin
            if (accept && (is_data || is_inval)) done <= 1'b0;
            if (accept && is_inval) frame_on <= 1'b0;
            if (go) begin
                rd_q   <= (cmd_op != OP_WR1);
                quad_q <= (cmd_op == OP_RD4);
                hcnt   <= '0;
                dcnt   <= '0;
                hlast  <= hlast_new;
                if (!frame_on) begin
                    frame_on   <= 1'b1;
                    frame_left <= cmd_len;
                    cur_cs     <= cmd_cs;
                    dly_last   <= {dcs[cmd_cs].delay, 1'b0} - 3'd1;
                end
            end
            if (state == ST_DELAY && tick) dcnt <= dcnt + 3'd1;
            if (state == ST_SHIFT && tick) begin
                phase_q <= !phase_q;
                hcnt    <= hcnt + 1'b1;
            end
            if (word_end) begin
                done <= 1'b1;
                if (frame_left <= FRAME_W'(1)) begin
                    frame_on   <= 1'b0;
                    frame_left <= '0;
                end else begin
                    frame_left <= frame_left - 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        load    = go;
        load_rd = (cmd_op != OP_WR1);
        sclk    = phase_q ^ dcs[cur_cs].cpol;
        samp    = dcs[cur_cs].cpha ? trail : lead;
        shft    = dcs[cur_cs].cpha ? (lead && hcnt != '0) : trail;
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign cs_o[g] = (frame_on && cur_cs == CSW'(g)) ? dcs[g].cspol : !dcs[g].cspol;
    end

    // R8: a disabled clock freezes the serial clock phase
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(phase_q));

    // R10: a word only runs inside an open frame
    a_r10_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> frame_on);

    // R11: completion is reported only when idle
    a_r11_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == ST_IDLE));

    // R11: a command written while shifting leaves the word length alone
    a_r11_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && cmd_wr) |=> $stable(hlast));

    // R7: the serial clock phase is back at rest whenever the engine is idle
    a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !phase_q);

endmodule

// File: rtl/sfx_engine.sv
module sfx_engine
    import sfx_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int MAXW    = 128,
    parameter int REG_W   = 32,
    parameter int DIV_W   = 16,
    parameter int FRAME_W = 12
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [$clog2(MAXW/REG_W + 3)-1:0]     wr_addr,
    input  logic [REG_W-1:0]                      wr_data,
    input  logic [3:0]                            dq_in,
    output logic                                  sclk,
    output logic [NUM_CS-1:0]                     cs_o,
    output logic                                  mosi,
    output logic                                  busy,
    output logic                                  word_done,
    output logic [MAXW-1:0]                       rx_word
);

    localparam int NDATA   = MAXW / REG_W;
    localparam int ADDR_W  = $clog2(NDATA + 3);
    localparam int LW      = $clog2(MAXW);
    localparam int CSW     = $clog2(NUM_CS);
    localparam int A_CLK   = 0;
    localparam int A_DEV   = 1;
    localparam int A_CMD   = 2;
    localparam int A_DATA0 = 3;

    logic             clk_en_q;
    logic [DIV_W-1:0] div_q;
    devctl_t          dcs [NUM_CS];
    logic [REG_W-1:0] data_q [NDATA];
    logic [MAXW-1:0]  tx_word;
    logic             cmd_wr, tick, load, load_rd, rd_q, quad_q, samp, shft;
    logic [NUM_CS-1:0] pol_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
            div_q    <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(A_CLK)) begin
            clk_en_q <= wr_data[REG_W-1];
            div_q    <= wr_data[DIV_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_dev
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  dcs[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(A_DEV)) dcs[g] <= wr_data[g*8 +: 5];
        end
        assign pol_v[g] = dcs[g].cspol;
    end

    for (genvar g = 0; g < NDATA; g++) begin : g_data
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        data_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(A_DATA0 + g)) data_q[g] <= wr_data;
        end
        assign tx_word[g*REG_W +: REG_W] = data_q[g];
    end

    assign cmd_wr = wr_en && (wr_addr == ADDR_W'(A_CMD));

    sfx_clkdiv #(.DIV_W(DIV_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (clk_en_q),
        .run   (busy),
        .div   (div_q),
        .tick  (tick)
    );

    sfx_ctrl #(.NUM_CS(NUM_CS), .FRAME_W(FRAME_W), .LW(LW)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_en      (clk_en_q),
        .tick        (tick),
        .cmd_wr      (cmd_wr),
        .cmd_len     (wr_data[FRAME_W-1:0]),
        .cmd_op      (wr_data[18:16]),
        .cmd_wlen_m1 (wr_data[19 +: LW]),
        .cmd_cs      (wr_data[28 +: CSW]),
        .dcs         (dcs),
        .busy        (busy),
        .done        (word_done),
        .load        (load),
        .load_rd     (load_rd),
        .rd_q        (rd_q),
        .quad_q      (quad_q),
        .samp        (samp),
        .shft        (shft),
        .sclk        (sclk),
        .cs_o        (cs_o)
    );

    sfx_shift #(.MAXW(MAXW), .LW(LW)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_rd (load_rd),
        .wlen_m1 (wr_data[19 +: LW]),
        .tx_word (tx_word),
        .rd_q    (rd_q),
        .quad_q  (quad_q),
        .samp    (samp),
        .shft    (shft),
        .dq_in   (dq_in),
        .mosi    (mosi),
        .rx_word (rx_word)
    );

    // R10: at most one select is active at a time
    a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~(cs_o ^ pol_v)));

endmodule

// File: tb/test_sfx_engine.sv
`timescale 1ns/1ps
module test_sfx_engine;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   dq_in = '0;
    logic         sclk, mosi, busy, word_done;
    logic [3:0]   cs_o;
    logic [127:0] rx_word;

    int vectors = 0;
    int errors  = 0;

    // flash model configuration, written only by tasks
    logic         cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_quad = 1'b0;
    logic [127:0] s_tx = '0;
    // flash model state, written only by the model
    logic [127:0] cap = '0, sh = '0;
    int           busy_cyc = 0;
    logic         sclk_prev = 1'b0, busy_prev = 1'b0;

    always #4 clk = ~clk;

    sfx_engine i_sfx_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dq_in(dq_in), .sclk(sclk), .cs_o(cs_o), .mosi(mosi), .busy(busy),
        .word_done(word_done), .rx_word(rx_word)
    );

    // flash device model, acting between clock edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !busy_prev) begin
                cap = '0;
                busy_cyc = 0;
                sh = s_tx;
                if (!cfg_cpha) begin
                    dq_in = cfg_quad ? sh[127:124] : {2'b00, sh[127], 1'b0};
                    sh = cfg_quad ? (sh << 4) : (sh << 1);
                end
            end
            if (busy) busy_cyc = busy_cyc + 1;
            if (sclk !== sclk_prev) begin
                if ((cfg_cpha ? (sclk == cfg_cpol) : (sclk != cfg_cpol))) begin
                    cap = {cap[126:0], mosi};
                end else begin
                    dq_in = cfg_quad ? sh[127:124] : {2'b00, sh[127], 1'b0};
                    sh = cfg_quad ? (sh << 4) : (sh << 1);
                end
            end
            sclk_prev = sclk;
            busy_prev = busy;
        end
    end

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input int len, input int op, input int wl, input int cs);
        return 32'(len) | (32'(op) << 16) | (32'(wl - 1) << 19) | (32'(cs) << 28);
    endfunction

    task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (busy) chk("watchdog wait_idle", 1, 0);
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [31:0] dc, input logic pol, input logic pha, input logic q);
        cfg_cpol = pol; cfg_cpha = pha; cfg_quad = q;
        host_wr(3'd1, dc);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 busy", 128'(busy), 0);
        chk("R1 word_done", 128'(word_done), 0);
        chk("R1 sclk", 128'(sclk), 0);
        chk("R1 cs_o", 128'(cs_o), 128'hF);
        chk("R1 mosi", 128'(mosi), 0);
        chk("R1 rx_word", rx_word, 0);
    endtask

    task automatic t_write8();
        host_wr(3'd0, 32'h8000_0000);
        set_cfg(32'h0, 1'b0, 1'b0, 1'b0);
        s_tx = '0;
        host_wr(3'd3, 32'h0000_00A5);
        host_wr(3'd2, mk_cmd(1, 2, 8, 0));
        chk("R10 cs asserted", 128'(cs_o), 128'hE);
        wait_idle();
        chk("R4 write 8 bits", 128'(cap[7:0]), 128'hA5);
        chk("R7 busy cycles div0", 128'(busy_cyc), 16);
        chk("R11 word_done set", 128'(word_done), 1);
        chk("R10 cs released", 128'(cs_o), 128'hF);
        chk("R7 sclk rests low", 128'(sclk), 0);
    endtask

    task automatic t_write128();
        host_wr(3'd0, 32'h8000_0002);
        set_cfg(32'h0000_0500, 1'b1, 1'b1, 1'b0);
        host_wr(3'd3, 32'h0123_4567);
        host_wr(3'd4, 32'h89AB_CDEF);
        host_wr(3'd5, 32'h5566_7788);
        host_wr(3'd6, 32'hF0E1_D2C3);
        host_wr(3'd2, mk_cmd(1, 2, 128, 1));
        chk("R10 cs1 asserted", 128'(cs_o), 128'hD);
        wait_idle();
        chk("R2 R4 128-bit register order", cap,
            128'hF0E1_D2C3_5566_7788_89AB_CDEF_0123_4567);
        chk("R7 busy cycles div2", 128'(busy_cyc), 768);
        chk("R9 sclk rests high", 128'(sclk), 1);
    endtask

    task automatic t_read1();
        host_wr(3'd0, 32'h8000_0001);
        set_cfg(32'h0000_0004, 1'b0, 1'b1, 1'b0);
        s_tx = 128'hC3A9 << 112;
        host_wr(3'd2, mk_cmd(1, 1, 16, 0));
        wait_idle();
        chk("R5 R9 single read trailing sample", rx_word, 128'hC3A9);
        chk("R7 busy cycles div1", 128'(busy_cyc), 64);
        set_cfg(32'h0, 1'b0, 1'b0, 1'b0);
        s_tx = 128'h9E5 << 116;
        host_wr(3'd2, mk_cmd(1, 1, 12, 0));
        wait_idle();
        chk("R5 R9 single read leading sample", rx_word, 128'h9E5);
    endtask

    task automatic t_quad();
        host_wr(3'd0, 32'h8000_0000);
        set_cfg(32'h0, 1'b0, 1'b0, 1'b1);
        s_tx = 128'h1234_5678 << 96;
        host_wr(3'd2, mk_cmd(1, 7, 32, 0));
        wait_idle();
        chk("R6 quad read data", rx_word, 128'h1234_5678);
        chk("R6 quad read periods", 128'(busy_cyc), 16);
        cfg_quad = 1'b0;
        s_tx = '0;
    endtask

    task automatic t_frame();
        set_cfg(32'h0002_0000, 1'b0, 1'b0, 1'b0);
        chk("R9 active-high select idles low", 128'(cs_o), 128'hB);
        host_wr(3'd3, 32'h3C);
        host_wr(3'd2, mk_cmd(3, 2, 8, 2));
        wait_idle();
        chk("R10 held after word 1", 128'(cs_o), 128'hF);
        host_wr(3'd3, 32'h96);
        host_wr(3'd2, mk_cmd(3, 2, 8, 0));
        chk("R10 select field ignored in frame", 128'(cs_o), 128'hF);
        wait_idle();
        chk("R10 word 2 data", 128'(cap[7:0]), 128'h96);
        chk("R10 held after word 2", 128'(cs_o), 128'hF);
        host_wr(3'd2, mk_cmd(3, 2, 8, 1));
        wait_idle();
        chk("R10 released after word 3", 128'(cs_o), 128'hB);
    endtask

    task automatic t_invalidate();
        set_cfg(32'h0, 1'b0, 1'b0, 1'b0);
        host_wr(3'd2, mk_cmd(5, 2, 8, 3));
        wait_idle();
        chk("R10 frame open", 128'(cs_o), 128'h7);
        host_wr(3'd2, mk_cmd(0, 4, 1, 0));
        chk("R3 R10 invalidate releases", 128'(cs_o), 128'hF);
        chk("R11 invalidate clears done", 128'(word_done), 0);
        chk("R3 invalidate stays idle", 128'(busy), 0);
    endtask

    task automatic t_unknown_op();
        host_wr(3'd2, mk_cmd(1, 2, 4, 0));
        wait_idle();
        host_wr(3'd2, mk_cmd(1, 3, 8, 0));
        @(negedge clk);
        chk("R3 unknown op not busy", 128'(busy), 0);
        chk("R3 unknown op keeps done", 128'(word_done), 1);
        chk("R3 unknown op keeps cs", 128'(cs_o), 128'hF);
    endtask

    task automatic t_busy_ignore();
        host_wr(3'd0, 32'h8000_0003);
        host_wr(3'd3, 32'h5A);
        host_wr(3'd2, mk_cmd(1, 2, 8, 0));
        chk("R11 done cleared by command", 128'(word_done), 0);
        host_wr(3'd2, mk_cmd(1, 2, 16, 1));
        wait_idle();
        chk("R11 busy command ignored data", 128'(cap[7:0]), 128'h5A);
        chk("R11 busy command ignored length", 128'(busy_cyc), 64);
        chk("R11 busy command ignored cs", 128'(cs_o), 128'hF);
    endtask

    task automatic t_clk_gate();
        logic s0;
        int   bad = 0;
        host_wr(3'd0, 32'h8000_0001);
        host_wr(3'd3, 32'hBEEF);
        host_wr(3'd2, mk_cmd(1, 2, 16, 0));
        repeat (10) @(negedge clk);
        host_wr(3'd0, 32'h0000_0001);
        @(negedge clk);
        s0 = sclk;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (sclk !== s0 || !busy) bad++;
        end
        chk("R8 sclk frozen while disabled", 128'(bad), 0);
        host_wr(3'd0, 32'h8000_0001);
        wait_idle();
        chk("R8 word completes after resume", 128'(cap[15:0]), 128'hBEEF);
    endtask

    task automatic t_delay();
        host_wr(3'd0, 32'h8000_0001);
        set_cfg(32'h0000_0010, 1'b0, 1'b0, 1'b0);
        host_wr(3'd3, 32'h81);
        host_wr(3'd2, mk_cmd(1, 2, 8, 0));
        repeat (9) @(negedge clk);
        chk("R12 sclk idle during delay", 128'(sclk), 0);
        @(negedge clk);
        chk("R12 first edge after delay", 128'(sclk), 1);
        wait_idle();
        chk("R12 busy includes delay", 128'(busy_cyc), 40);
        chk("R12 data after delay", 128'(cap[7:0]), 128'h81);
    endtask

    initial begin
        #(8 * 150000);
        chk("watchdog expired", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write8();
        t_write128();
        t_read1();
        t_quad();
        t_frame();
        t_invalidate();
        t_unknown_op();
        t_busy_ignore();
        t_clk_gate();
        t_delay();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule